// File: doc/BRIEF.md
# Machine-Cycle Timer and Event Counter

This block is one timer/counter channel of the kind found next to a small 8-bit processor core. It runs on the oscillator clock and derives its own machine-cycle strobe, one pulse every twelve clocks, from a modulo counter. In timer operation the count advances once per machine cycle. In event operation it advances once for each falling edge seen on an external pin. That pin passes through a synchronizer and is then sampled once per machine cycle. A second external pin can gate counting, which lets software measure how long that pin stays high.

Software sees four byte-wide registers: the low count byte, the high count byte, a mode register and a control register. The mode register picks one of three counting structures and holds the event-select and gate bits. In the 13-bit structure, five low bits act as a prescaler in front of the high byte. The 16-bit structure is a plain 16-bit counter. In the auto-reload structure, the low byte counts and is refilled from the high byte. When the count wraps, an overflow flag is set. It drives the interrupt output and stays set until software writes it clear.

Top module: `cyc_timer`

## Requirements
- R1: Register map on `addr`. 0 is the low count byte and 1 is the high count byte. 2 is the mode register: bits 1:0 select the structure, bit 2 set selects event counting, bit 3 set enables the gate pin. 3 is the control register: bit 0 is run and bit 1 is the overflow flag. Unused bits read as zero and ignore writes.
- R2: After reset, all four registers read zero and `ovf_irq` is low.
- R3: In timer operation the count advances by exactly one per 12-clock machine cycle, and only on the clock edge that ends a machine cycle.
- R4: The count advances only when run is 1 and either the gate bit is 0 or `gate_pin` is high. Otherwise the count bytes hold their value.
- R5: In event operation, `evt_pin` is synchronized and sampled once per machine cycle. A high sample followed by a low sample adds one. A pin toggling every 12 clocks therefore counts once per 24 clocks. A pin toggling every 6 clocks is always sampled at the same level and adds at most one over a whole burst.
- R6: Mode 00 (13-bit): the low five bits of the low byte count. Their carry advances the high byte. Bits 7:5 of the low byte keep their written value.
- R7: Mode 01 (16-bit): the high and low bytes form one 16-bit counter.
- R8: Mode 10 (auto-reload): the low byte counts. When it passes 0xFF it is loaded from the high byte, and the high byte never changes by counting.
- R9: Mode 11 does not count; both count bytes hold.
- R10: When the count passes from all ones to all zeros, the overflow flag is set. It stays set until control bit 1 is written as 0, and `ovf_irq` equals the flag.
- R11: A write to a count byte on the same edge as an increment takes the written value, and no increment happens on that edge.
- R12: An overflow on the same edge as a control write that clears the flag leaves the flag set.
- R13: Setting the run bit leaves the count bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the register selected by `addr` |
| evt_pin | input | 1 | External event input, counted on falling edges |
| gate_pin | input | 1 | External gate input |
| ovf_irq | output | 1 | Overflow interrupt flag |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a software write to a count byte and a counting step. The second pair is a hardware overflow and a software write that clears the flag. The bench starts the run on an edge that ends a machine cycle, waits exactly eleven clocks, and then issues the low-byte write, or the flag-clearing control write, so that it lands on the next counting edge. It stops the run one machine cycle later. The final count shows whether the write won and whether the extra increment was lost. For the second pair, the flag read back and `ovf_irq` show whether the hardware set was kept.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

   localparam int REG_ADDR_W = 2;

   localparam logic [REG_ADDR_W-1:0] REG_LO   = 2'd0;
   localparam logic [REG_ADDR_W-1:0] REG_HI   = 2'd1;
   localparam logic [REG_ADDR_W-1:0] REG_MODE = 2'd2;
   localparam logic [REG_ADDR_W-1:0] REG_CTRL = 2'd3;

   // control register bits
   localparam int CTL_RUN  = 0;
   localparam int CTL_FLAG = 1;
   // mode register bits
   localparam int MD_EVT   = 2;
   localparam int MD_GATE  = 3;

   typedef enum logic [1:0] {
      MODE_13  = 2'b00,
      MODE_16  = 2'b01,
      MODE_RLD = 2'b10,
      MODE_OFF = 2'b11
   } tmode_e;

endpackage

// File: rtl/cyc_timer_sync.sv
module cyc_timer_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] sh;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign dout = sh[STAGES-1];

endmodule

// File: rtl/cyc_timer_phase.sv
module cyc_timer_phase #(
   parameter int DIV          = 12,
   parameter int SAMPLE_PHASE = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick,
   output logic samp
);

   localparam int PH_W = $clog2(DIV);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
   localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SAMPLE_PHASE);

   logic [PH_W-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ph <= '0;
      else if (ph == PH_LAST) ph <= '0;
      else                   ph <= ph + 1'b1;
   end

   assign tick = (ph == PH_LAST);
   assign samp = (ph == PH_SMP);

endmodule

// File: rtl/cyc_timer_edge.sv
module cyc_timer_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic samp,
   input  logic tick,
   output logic hit
);

   logic smp_q;
   logic hit_q;

   // sample once per machine cycle; a high-then-low pair arms the hit,
   // which the cycle-ending tick consumes whether or not it counts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= 1'b0;
         hit_q <= 1'b0;
      end else if (samp) begin
         smp_q <= pin_s;
         if (smp_q && !pin_s) hit_q <= 1'b1;
      end else if (tick) begin
         hit_q <= 1'b0;
      end
   end

   assign hit = hit_q;

endmodule

// File: rtl/cyc_timer_core.sv
module cyc_timer_core
   import cyc_timer_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int PRESC_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  tmode_e            mode,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] cnt_lo,
   output logic [BYTE_W-1:0] cnt_hi,
   output logic              ovf_pulse
);

   localparam int FULL_W = 2 * BYTE_W;

   logic [BYTE_W-1:0]  nxt_lo;
   logic [BYTE_W-1:0]  nxt_hi;
   logic [PRESC_W-1:0] pre_inc;
   logic [FULL_W-1:0]  full_inc;
   logic               wrap;
   logic               sw_wr;

   assign pre_inc  = cnt_lo[PRESC_W-1:0] + PRESC_W'(1);
   assign full_inc = {cnt_hi, cnt_lo} + FULL_W'(1);
   assign sw_wr    = wr_lo | wr_hi;

   always_comb begin
      nxt_lo = cnt_lo;
      nxt_hi = cnt_hi;
      wrap   = 1'b0;
      unique case (mode)
         MODE_13: begin
            nxt_lo = {cnt_lo[BYTE_W-1:PRESC_W], pre_inc};
            if (&cnt_lo[PRESC_W-1:0]) begin
               nxt_hi = cnt_hi + 1'b1;
               wrap   = &cnt_hi;
            end
         end
         MODE_16: begin
            {nxt_hi, nxt_lo} = full_inc;
            wrap             = &{cnt_hi, cnt_lo};
         end
         MODE_RLD: begin
            if (&cnt_lo) begin
               nxt_lo = cnt_hi;
               wrap   = 1'b1;
            end else begin
               nxt_lo = cnt_lo + 1'b1;
            end
         end
         default: begin
            nxt_lo = cnt_lo;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else if (sw_wr) begin
         if (wr_lo) cnt_lo <= wr_data;
         if (wr_hi) cnt_hi <= wr_data;
      end else if (step) begin
         cnt_lo <= nxt_lo;
         cnt_hi <= nxt_hi;
      end
   end

   assign ovf_pulse = step & ~sw_wr & wrap;

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
   import cyc_timer_pkg::*;
#(
   parameter int CLK_DIV      = 12,
   parameter int SAMPLE_PHASE = 5,
   parameter int SYNC_STAGES  = 2,
   parameter int BYTE_W       = 8,
   parameter int PRESC_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0]     wr_data,
   output logic [BYTE_W-1:0]     rd_data,
   input  logic                  evt_pin,
   input  logic                  gate_pin,
   output logic                  ovf_irq
);

   if (CLK_DIV < 2) begin : g_bad_div
      $error("cyc_timer: CLK_DIV must be at least 2");
   end
   if (SAMPLE_PHASE < 0 || SAMPLE_PHASE >= CLK_DIV - 1) begin : g_bad_phase
      $error("cyc_timer: SAMPLE_PHASE must lie before the last phase");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cyc_timer: SYNC_STAGES must be at least 2");
   end
   if (BYTE_W < 4 || PRESC_W < 1 || PRESC_W >= BYTE_W) begin : g_bad_width
      $error("cyc_timer: need BYTE_W >= 4 and 0 < PRESC_W < BYTE_W");
   end

   logic        tick;
   logic        samp;
   logic        evt_s;
   logic        gate_s;
   logic        edge_hit;
   logic        step;
   logic        ovf_pulse;
   logic        wr_lo;
   logic        wr_hi;
   logic        wr_mode;
   logic        wr_ctrl;
   logic        run_q;
   logic        flag_q;
   logic        evt_sel_q;
   logic        gate_q;
   tmode_e      mode_q;
   logic [BYTE_W-1:0] cnt_lo;
   logic [BYTE_W-1:0] cnt_hi;

   assign wr_lo   = wr_en && (addr == REG_LO);
   assign wr_hi   = wr_en && (addr == REG_HI);
   assign wr_mode = wr_en && (addr == REG_MODE);
   assign wr_ctrl = wr_en && (addr == REG_CTRL);

   cyc_timer_phase #(
      .DIV          (CLK_DIV),
      .SAMPLE_PHASE (SAMPLE_PHASE)
   ) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .samp  (samp)
   );

   cyc_timer_sync #(.STAGES(SYNC_STAGES)) u_sync_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (evt_pin),
      .dout  (evt_s)
   );

   cyc_timer_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (gate_pin),
      .dout  (gate_s)
   );

   cyc_timer_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (evt_s),
      .samp  (samp),
      .tick  (tick),
      .hit   (edge_hit)
   );

   assign step = tick & run_q & (~gate_q | gate_s) & (evt_sel_q ? edge_hit : 1'b1);

   cyc_timer_core #(
      .BYTE_W  (BYTE_W),
      .PRESC_W (PRESC_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .mode      (mode_q),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .wr_data   (wr_data),
      .cnt_lo    (cnt_lo),
      .cnt_hi    (cnt_hi),
      .ovf_pulse (ovf_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_13;
         evt_sel_q <= 1'b0;
         gate_q    <= 1'b0;
      end else if (wr_mode) begin
         mode_q    <= tmode_e'(wr_data[1:0]);
         evt_sel_q <= wr_data[MD_EVT];
         gate_q    <= wr_data[MD_GATE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) run_q <= wr_data[CTL_RUN];
         if (ovf_pulse)    flag_q <= 1'b1;
         else if (wr_ctrl) flag_q <= wr_data[CTL_FLAG];
      end
   end

   always_comb begin
      unique case (addr)
         REG_LO:   rd_data = cnt_lo;
         REG_HI:   rd_data = cnt_hi;
         REG_MODE: rd_data = BYTE_W'({gate_q, evt_sel_q, mode_q});
         default:  rd_data = BYTE_W'({flag_q, run_q});
      endcase
   end

   assign ovf_irq = flag_q;

endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              step,
   input logic              ovf_pulse,
   input logic              wr_lo,
   input logic              wr_hi,
   input logic              wr_ctrl,
   input logic [BYTE_W-1:0] wr_data,
   input logic              run_q,
   input logic              flag_q,
   input logic [1:0]        mode_q,
   input logic [BYTE_W-1:0] cnt_lo,
   input logic [BYTE_W-1:0] cnt_hi
);

   logic primed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   AST_STEP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      (!$stable({cnt_hi, cnt_lo}) && !$past(wr_lo || wr_hi)) |-> $past(tick)) // R3
      else $error("count moved away from a machine-cycle boundary");

   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      ($past(!run_q) && !$past(wr_lo || wr_hi)) |-> $stable({cnt_hi, cnt_lo})) // R4
      else $error("count moved while run was clear");

   AST_RELOAD_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $past(step && mode_q == 2'b10 && cnt_lo == '1 && !wr_lo && !wr_hi) |-> (cnt_lo == $past(cnt_hi))) // R8
      else $error("reload did not take the high byte");

   AST_HIGH_FIXED_IN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $past(mode_q == 2'b10 && !wr_hi) |-> $stable(cnt_hi)) // R8
      else $error("high byte changed in reload mode");

   AST_MODE_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $past(mode_q == 2'b11 && !wr_lo && !wr_hi) |-> $stable({cnt_hi, cnt_lo})) // R9
      else $error("count moved in the halted mode");

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $fell(flag_q) |-> $past(wr_ctrl)) // R10
      else $error("flag dropped without a control write");

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $past(wr_lo) |-> (cnt_lo == $past(wr_data))) // R11
      else $error("low byte write lost to an increment");

   AST_OVERFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $past(ovf_pulse) |-> flag_q) // R12
      else $error("overflow did not leave the flag set");

endmodule

bind cyc_timer cyc_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .step      (step),
   .ovf_pulse (ovf_pulse),
   .wr_lo     (wr_lo),
   .wr_hi     (wr_hi),
   .wr_ctrl   (wr_ctrl),
   .wr_data   (wr_data),
   .run_q     (run_q),
   .flag_q    (flag_q),
   .mode_q    (mode_q),
   .cnt_lo    (cnt_lo),
   .cnt_hi    (cnt_hi)
);

// File: tb/cyc_timer_bench.sv
module cyc_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic       evt_pin = 1'b0;
   logic       gate_pin = 1'b0;
   logic       ovf_irq;

   int total = 0;
   int bad = 0;
   int edge_n = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) edge_n <= 0;
      else        edge_n <= edge_n + 1;
   end

   cyc_timer u_cyc_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .evt_pin  (evt_pin),
      .gate_pin (gate_pin),
      .ovf_irq  (ovf_irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rd_data;
   endtask

   // next posedge ends a machine cycle
   task automatic align();
      while ((edge_n % DIV) != DIV - 1) @(negedge clk);
   endtask

   task automatic start_run();
      logic [7:0] c;
      align();
      rd(2'd3, c);
      wr(2'd3, c | 8'h01);
   endtask

   task automatic stop_run();
      logic [7:0] c;
      align();
      rd(2'd3, c);
      wr(2'd3, c & 8'hFE);
   endtask

   task automatic run_ticks(input int k);
      start_run();
      idle(DIV * (k - 1));
      stop_run();
   endtask

   task automatic load(input logic [7:0] md, input logic [7:0] hi, input logic [7:0] lo);
      wr(2'd2, md);
      wr(2'd1, hi);
      wr(2'd0, lo);
      wr(2'd3, 8'h00);
   endtask

   task automatic check_cnt(input string tag, input logic [7:0] hi, input logic [7:0] lo);
      logic [7:0] v;
      rd(2'd0, v); check({tag, " low"}, v, lo);
      rd(2'd1, v); check({tag, " high"}, v, hi);
   endtask

   task automatic pulses(input int n, input int hi_len, input int lo_len);
      repeat (n) begin
         evt_pin = 1'b1; idle(hi_len);
         evt_pin = 1'b0; idle(lo_len);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R2 reset state
      rd(2'd0, v); check("R2 low", v, 8'h00);
      rd(2'd1, v); check("R2 high", v, 8'h00);
      rd(2'd2, v); check("R2 mode", v, 8'h00);
      rd(2'd3, v); check("R2 ctrl", v, 8'h00);
      check("R2 irq", {7'd0, ovf_irq}, 8'h00);

      // R1 register map: only four mode bits exist
      wr(2'd2, 8'hFF);
      rd(2'd2, v); check("R1 mode readback", v, 8'h0F);
      wr(2'd2, 8'h0D);
      rd(2'd2, v); check("R1 mode fields", v, 8'h0D);

      // R7, R13, R3: 16-bit timer, 20 machine cycles
      load(8'h01, 8'h12, 8'hF0);
      start_run();
      check_cnt("R13 run keeps count", 8'h12, 8'hF0);
      idle(DIV * 19);
      stop_run();
      check_cnt("R3 R7 16-bit", 8'h13, 8'h04);

      // R4: run clear holds the count
      wr(2'd0, 8'h33);
      idle(100);
      rd(2'd0, v); check("R4 stopped hold", v, 8'h33);

      // R10: 16-bit wrap sets the sticky flag
      load(8'h01, 8'hFF, 8'hFA);
      run_ticks(10);
      check_cnt("R10 16-bit wrap", 8'h00, 8'h04);
      rd(2'd3, v); check("R10 flag set", v, 8'h02);
      check("R10 irq high", {7'd0, ovf_irq}, 8'h01);
      idle(40);
      check("R10 irq stays", {7'd0, ovf_irq}, 8'h01);
      wr(2'd3, 8'h00);
      check("R10 irq cleared", {7'd0, ovf_irq}, 8'h00);

      // R6: 13-bit, upper low-byte bits kept
      load(8'h00, 8'h05, 8'hFC);
      run_ticks(10);
      check_cnt("R6 prescale carry", 8'h06, 8'hE6);
      load(8'h00, 8'hFF, 8'h1E);
      run_ticks(3);
      check_cnt("R6 13-bit wrap", 8'h00, 8'h01);
      rd(2'd3, v); check("R6 R10 13-bit flag", v, 8'h02);

      // R8: auto-reload, 7 steps from FE with reload FC
      load(8'h02, 8'hFC, 8'hFE);
      run_ticks(7);
      check_cnt("R8 reload", 8'hFC, 8'hFD);
      rd(2'd3, v); check("R8 reload flag", v, 8'h02);

      // R9: mode 11 halts
      load(8'h03, 8'h55, 8'h44);
      run_ticks(5);
      check_cnt("R9 halted mode", 8'h55, 8'h44);

      // R4: gate bit with gate pin low, then high, then gate bit clear
      gate_pin = 1'b0;
      load(8'h09, 8'h00, 8'h00);
      idle(4);
      run_ticks(15);
      check_cnt("R4 gated off", 8'h00, 8'h00);
      gate_pin = 1'b1;
      idle(4);
      run_ticks(15);
      check_cnt("R4 gated on", 8'h00, 8'h0F);
      gate_pin = 1'b0;
      wr(2'd2, 8'h01);
      idle(4);
      run_ticks(5);
      check_cnt("R4 gate unused", 8'h00, 8'h14);

      // R5: event counting, slow pulses
      evt_pin = 1'b0;
      load(8'h05, 8'h00, 8'h00);
      idle(2 * DIV);
      start_run();
      pulses(6, 30, 30);
      idle(4 * DIV);
      stop_run();
      check_cnt("R5 slow events", 8'h00, 8'h06);

      // R5: fastest countable rate, then two too-fast bursts half a cycle apart
      wr(2'd0, 8'h00);
      idle(2 * DIV);
      start_run();
      pulses(10, DIV, DIV);
      idle(30);
      pulses(20, DIV / 2, DIV / 2);
      idle(30);
      pulses(20, DIV / 2, DIV / 2);
      idle(4 * DIV);
      stop_run();
      check_cnt("R5 max rate", 8'h00, 8'h0B);

      // R11: low-byte write on the counting edge wins
      load(8'h01, 8'h00, 8'h00);
      start_run();
      idle(DIV - 1);
      wr(2'd0, 8'h80);
      stop_run();
      check_cnt("R11 write priority", 8'h00, 8'h81);

      // R12: overflow on the same edge as a flag clear
      load(8'h01, 8'hFF, 8'hFF);
      start_run();
      idle(DIV - 1);
      wr(2'd3, 8'h01);
      stop_run();
      check_cnt("R12 collision count", 8'h00, 8'h01);
      rd(2'd3, v); check("R12 flag kept", v, 8'h02);
      check("R12 irq kept", {7'd0, ovf_irq}, 8'h01);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule